// File: doc/BRIEF.md
# Five-Stage Pipeline Hazard Controller

This block is the hazard and control unit of an in-order pipeline with five stages: fetch, decode, execute, memory and writeback. It looks at the register specifiers, write enables and load/store flags of the instructions sitting in the decode, execute, memory and writeback latches. From these it decides each cycle whether fetch and the fetch/decode latch advance, whether a bubble enters the execute latch, and which source feeds each forwarding multiplexer. Its logic is purely combinational. The datapath registers its outputs at the next clock edge.

Branches are compared and their targets computed in decode. Fetch always assumes the branch is not taken. When decode reports a taken branch, the controller redirects the PC and turns the wrong-path instruction in the fetch/decode latch into a bubble. A configuration input selects between split and unified instruction/data memory. In unified mode, a load or store in the memory stage holds fetch for that cycle.

Top module: `pipe_hazard_ctrl`

## Requirements
- R1: With no hazard, `pc_we_o` and `ifid_we_o` are 1 and `idex_bubble_o` is 0. On a stall, `pc_we_o` and `ifid_we_o` are 0 and `idex_bubble_o` is 1.
- R2: A stall is raised when a load in execute writes a nonzero register that decode reads as `id_rs1_i`. It is also raised when that register matches `id_rs2_i`, unless the decode instruction is a store.
- R3: An ALU producer in execute never stalls a non-branch consumer in decode. For example, it does not stall a load that uses the result as its base address.
- R4: The execute forwarding select uses the codes 0 = register file, 1 = EX/MEM result and 2 = MEM/WB result. Code 1 is chosen when a non-load writer in memory matches the operand. Otherwise code 2 is chosen when a writer in writeback matches. EX/MEM takes priority over MEM/WB.
- R5: Register 0 never produces a forward, a decode forward, a store-data forward or a stall.
- R6: A writeback-stage writer that matches a decode operand causes no stall and no decode forward.
- R7: A branch in decode stalls while a writer in execute matches one of its operands, and while a load in memory matches one. An ALU producer therefore costs one stall and a load costs two.
- R8: A branch operand that matches a non-load writer in memory sets the matching decode forward select (`id_fwd_a_o` / `id_fwd_b_o`) to 1.
- R9: A taken branch with no stall asserts `ifid_squash_o` and `pc_redirect_o`. A branch that is not taken asserts neither.
- R10: If a stall and a taken branch fall in the same cycle, squash and redirect stay 0 and the stall wins.
- R11: In unified mode (`unified_mem_i`=1), a load or store in memory stalls. In split mode it does not.
- R12: `st_fwd_o` is 1 when a store is in memory and a writeback writer's nonzero destination equals the store's data register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, used only by assertions |
| rst_n | input | 1 | Synchronous active-low reset, used only by assertions |
| unified_mem_i | input | 1 | 1 = shared instruction/data memory |
| id_rs1_i | input | AW | Decode source register 1 |
| id_rs2_i | input | AW | Decode source register 2 (store data for stores) |
| id_is_store_i | input | 1 | Decode instruction is a store |
| id_is_branch_i | input | 1 | Decode instruction is a branch |
| id_br_taken_i | input | 1 | Decode branch comparison result |
| ex_rs1_i | input | AW | Execute source register 1 |
| ex_rs2_i | input | AW | Execute source register 2 |
| ex_rd_i | input | AW | Execute destination register |
| ex_wen_i | input | 1 | Execute instruction writes a register |
| ex_is_load_i | input | 1 | Execute instruction is a load |
| mem_rd_i | input | AW | Memory-stage destination register |
| mem_wen_i | input | 1 | Memory-stage instruction writes a register |
| mem_is_load_i | input | 1 | Memory-stage instruction is a load |
| mem_is_store_i | input | 1 | Memory-stage instruction is a store |
| mem_rs2_i | input | AW | Memory-stage store data register |
| wb_rd_i | input | AW | Writeback destination register |
| wb_wen_i | input | 1 | Writeback instruction writes a register |
| pc_we_o | output | 1 | PC update enable |
| ifid_we_o | output | 1 | Fetch/decode latch enable |
| idex_bubble_o | output | 1 | Clear controls entering execute |
| ifid_squash_o | output | 1 | Turn fetched instruction into a bubble |
| pc_redirect_o | output | 1 | Load branch target into PC |
| ex_fwd_a_o | output | 2 | Execute operand A source select |
| ex_fwd_b_o | output | 2 | Execute operand B source select |
| id_fwd_a_o | output | 1 | Decode operand A from EX/MEM |
| id_fwd_b_o | output | 1 | Decode operand B from EX/MEM |
| st_fwd_o | output | 1 | Store data from MEM/WB into memory stage |

## Verification
A stall and a taken-branch squash can fall in the same cycle. The contest is provoked in two ways. The first presents a taken branch whose operand is still being produced in execute or loaded in memory. The second presents a taken branch while unified mode has a memory access in flight. The bench judges the outcome by requiring the fetch enables low, the bubble high, and both squash and redirect low. It then withdraws the producer and expects squash and redirect to rise with fetch enabled. Random stimulus over a four-register space makes these collisions frequent, and every cycle is compared against a bench model.

// File: rtl/hz_pkg.sv
// Shared types for the pipeline hazard controller.
package hz_pkg;
    typedef enum logic [1:0] {
        FWD_NONE  = 2'd0,
        FWD_EXMEM = 2'd1,
        FWD_MEMWB = 2'd2
    } fwd_sel_e;
endpackage

// File: rtl/hz_ex_fwd.sv
// Execute-stage forwarding select for one operand.
// Assumes loads in MEM have no data yet on the EX/MEM path; the load-use
// stall guarantees such a consumer never reaches EX alongside its load.
module hz_ex_fwd
    import hz_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic [AW-1:0] src_i,
    input  logic [AW-1:0] mem_rd_i,
    input  logic          mem_wen_i,
    input  logic          mem_is_load_i,
    input  logic [AW-1:0] wb_rd_i,
    input  logic          wb_wen_i,
    output fwd_sel_e      sel_o
);
    logic src_live;
    logic hit_mem;
    logic hit_wb;

    // Match terms; register 0 is excluded.
    always_comb begin
        src_live = (src_i != '0);
        hit_mem  = src_live && mem_wen_i && !mem_is_load_i && (mem_rd_i == src_i);
        hit_wb   = src_live && wb_wen_i && (wb_rd_i == src_i);
    end

    // Priority pick: newest value wins.
    always_comb begin
        if (hit_mem)     sel_o = FWD_EXMEM;
        else if (hit_wb) sel_o = FWD_MEMWB;
        else             sel_o = FWD_NONE;
    end
endmodule

// File: rtl/hz_stall_unit.sv
// Stall decision: load-use, decode-branch operand, and shared memory port.
// Assumes a WB writer is visible to decode through a half-cycle register file.
module hz_stall_unit #(
    parameter int AW = 5
) (
    input  logic          unified_mem_i,
    input  logic [AW-1:0] id_rs1_i,
    input  logic [AW-1:0] id_rs2_i,
    input  logic          id_is_store_i,
    input  logic          id_is_branch_i,
    input  logic [AW-1:0] ex_rd_i,
    input  logic          ex_wen_i,
    input  logic          ex_is_load_i,
    input  logic [AW-1:0] mem_rd_i,
    input  logic          mem_is_load_i,
    input  logic          mem_is_store_i,
    output logic          stall_o
);
    logic ex_m1, ex_m2, mem_m1, mem_m2;
    logic load_use, br_wait, port_busy;

    // Operand match against EX and MEM destinations (nonzero only).
    always_comb begin
        ex_m1  = (ex_rd_i != '0) && (ex_rd_i == id_rs1_i);
        ex_m2  = (ex_rd_i != '0) && (ex_rd_i == id_rs2_i);
        mem_m1 = (mem_rd_i != '0) && (mem_rd_i == id_rs1_i);
        mem_m2 = (mem_rd_i != '0) && (mem_rd_i == id_rs2_i);
    end

    // Combine the three stall causes.
    always_comb begin
        load_use  = ex_is_load_i && (ex_m1 || (ex_m2 && !id_is_store_i));
        br_wait   = id_is_branch_i &&
                    ((ex_wen_i && (ex_m1 || ex_m2)) ||
                     (mem_is_load_i && (mem_m1 || mem_m2)));
        port_busy = unified_mem_i && (mem_is_load_i || mem_is_store_i);
        stall_o   = load_use || br_wait || port_busy;
    end
endmodule

// File: rtl/hz_branch_unit.sv
// Decode-stage branch support: operand forwarding from EX/MEM and the
// predict-not-taken squash/redirect. A stall defers the squash until the
// branch may leave decode.
module hz_branch_unit #(
    parameter int AW = 5
) (
    input  logic          id_is_branch_i,
    input  logic          id_br_taken_i,
    input  logic [AW-1:0] id_rs1_i,
    input  logic [AW-1:0] id_rs2_i,
    input  logic [AW-1:0] mem_rd_i,
    input  logic          mem_wen_i,
    input  logic          mem_is_load_i,
    input  logic          stall_i,
    output logic          fwd_a_o,
    output logic          fwd_b_o,
    output logic          squash_o,
    output logic          redirect_o
);
    logic alu_in_mem;

    // Forward a finished ALU result into the comparator.
    always_comb begin
        alu_in_mem = id_is_branch_i && mem_wen_i && !mem_is_load_i && (mem_rd_i != '0);
        fwd_a_o    = alu_in_mem && (mem_rd_i == id_rs1_i);
        fwd_b_o    = alu_in_mem && (mem_rd_i == id_rs2_i);
    end

    // Squash the wrong-path fetch only when the branch really leaves decode.
    always_comb begin
        squash_o   = id_is_branch_i && id_br_taken_i && !stall_i;
        redirect_o = squash_o;
    end
endmodule

// File: rtl/pipe_hazard_ctrl.sv
// Hazard and control unit of a five-stage in-order pipeline.
// Purely combinational; clk/rst_n serve only the embedded assertions.
// Assumes a load always has its write enable set.
module pipe_hazard_ctrl
    import hz_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          unified_mem_i,
    input  logic [AW-1:0] id_rs1_i,
    input  logic [AW-1:0] id_rs2_i,
    input  logic          id_is_store_i,
    input  logic          id_is_branch_i,
    input  logic          id_br_taken_i,
    input  logic [AW-1:0] ex_rs1_i,
    input  logic [AW-1:0] ex_rs2_i,
    input  logic [AW-1:0] ex_rd_i,
    input  logic          ex_wen_i,
    input  logic          ex_is_load_i,
    input  logic [AW-1:0] mem_rd_i,
    input  logic          mem_wen_i,
    input  logic          mem_is_load_i,
    input  logic          mem_is_store_i,
    input  logic [AW-1:0] mem_rs2_i,
    input  logic [AW-1:0] wb_rd_i,
    input  logic          wb_wen_i,
    output logic          pc_we_o,
    output logic          ifid_we_o,
    output logic          idex_bubble_o,
    output logic          ifid_squash_o,
    output logic          pc_redirect_o,
    output logic [1:0]    ex_fwd_a_o,
    output logic [1:0]    ex_fwd_b_o,
    output logic          id_fwd_a_o,
    output logic          id_fwd_b_o,
    output logic          st_fwd_o
);
    localparam int NOPS = 2;

    logic          stall;
    logic [AW-1:0] ex_src [NOPS];
    fwd_sel_e      ex_sel [NOPS];

    assign ex_src[0] = ex_rs1_i;
    assign ex_src[1] = ex_rs2_i;

    // One forwarding selector per execute operand.
    for (genvar g = 0; g < NOPS; g++) begin : g_exfwd
        hz_ex_fwd #(.AW(AW)) i_fwd (
            .src_i         (ex_src[g]),
            .mem_rd_i      (mem_rd_i),
            .mem_wen_i     (mem_wen_i),
            .mem_is_load_i (mem_is_load_i),
            .wb_rd_i       (wb_rd_i),
            .wb_wen_i      (wb_wen_i),
            .sel_o         (ex_sel[g])
        );
    end

    assign ex_fwd_a_o = ex_sel[0];
    assign ex_fwd_b_o = ex_sel[1];

    hz_stall_unit #(.AW(AW)) i_stall (
        .unified_mem_i  (unified_mem_i),
        .id_rs1_i       (id_rs1_i),
        .id_rs2_i       (id_rs2_i),
        .id_is_store_i  (id_is_store_i),
        .id_is_branch_i (id_is_branch_i),
        .ex_rd_i        (ex_rd_i),
        .ex_wen_i       (ex_wen_i),
        .ex_is_load_i   (ex_is_load_i),
        .mem_rd_i       (mem_rd_i),
        .mem_is_load_i  (mem_is_load_i),
        .mem_is_store_i (mem_is_store_i),
        .stall_o        (stall)
    );

    hz_branch_unit #(.AW(AW)) i_branch (
        .id_is_branch_i (id_is_branch_i),
        .id_br_taken_i  (id_br_taken_i),
        .id_rs1_i       (id_rs1_i),
        .id_rs2_i       (id_rs2_i),
        .mem_rd_i       (mem_rd_i),
        .mem_wen_i      (mem_wen_i),
        .mem_is_load_i  (mem_is_load_i),
        .stall_i        (stall),
        .fwd_a_o        (id_fwd_a_o),
        .fwd_b_o        (id_fwd_b_o),
        .squash_o       (ifid_squash_o),
        .redirect_o     (pc_redirect_o)
    );

    // Latch enables and bubble insert follow the stall decision.
    always_comb begin
        pc_we_o       = !stall;
        ifid_we_o     = !stall;
        idex_bubble_o = stall;
    end

    // Store data forwarded from a writeback producer into the memory stage.
    always_comb begin
        st_fwd_o = mem_is_store_i && wb_wen_i && (wb_rd_i != '0) && (wb_rd_i == mem_rs2_i);
    end

    // Load-use on operand 1 must freeze fetch and bubble execute.
    p_load_use_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_is_load_i && ex_rd_i != '0 && ex_rd_i == id_rs1_i) |-> (!pc_we_o && idex_bubble_o));

    // EX/MEM beats MEM/WB when both match.
    p_fwd_prio_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wen_i && !mem_is_load_i && mem_rd_i != '0 && mem_rd_i == ex_rs1_i
         && wb_wen_i && wb_rd_i == ex_rs1_i) |-> (ex_fwd_a_o == 2'd1));

    // Register 0 is never a forwarding source.
    p_zero_reg_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_rs2_i == '0) |-> (ex_fwd_b_o == 2'd0));

    // A load in memory matching a branch operand blocks decode.
    p_br_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (id_is_branch_i && mem_is_load_i && mem_rd_i != '0 && mem_rd_i == id_rs1_i)
        |-> (idex_bubble_o && !id_fwd_a_o));

    // Squash only happens when fetch is allowed to move.
    p_squash_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ifid_squash_o |-> (pc_we_o && ifid_we_o && pc_redirect_o));

    // Shared memory port busy freezes fetch.
    p_unified_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (unified_mem_i && (mem_is_load_i || mem_is_store_i)) |-> (!ifid_we_o && !ifid_squash_o));

    // Store-data forward only with a live store in memory.
    p_st_fwd_r12: assert property (@(posedge clk) disable iff (!rst_n)
        st_fwd_o |-> (mem_is_store_i && wb_rd_i != '0));
endmodule

// File: tb/test_pipe_hazard_ctrl.sv
// Bench: random latch contents over a small register space plus directed
// corner cases, compared against an independent model every cycle.
module test_pipe_hazard_ctrl;
    localparam int AW = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic          unified, id_st, id_br, id_tk, ex_wen, ex_ld, mem_wen, mem_ld, mem_st, wb_wen;
    logic [AW-1:0] id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, mem_rd, mem_rs2, wb_rd;
    logic          pc_we, ifid_we, bubble, squash, redirect, idf_a, idf_b, stf;
    logic [1:0]    exf_a, exf_b;

    pipe_hazard_ctrl #(.AW(AW)) i_pipe_hazard_ctrl (
        .clk(clk), .rst_n(rst_n), .unified_mem_i(unified),
        .id_rs1_i(id_rs1), .id_rs2_i(id_rs2), .id_is_store_i(id_st),
        .id_is_branch_i(id_br), .id_br_taken_i(id_tk),
        .ex_rs1_i(ex_rs1), .ex_rs2_i(ex_rs2), .ex_rd_i(ex_rd),
        .ex_wen_i(ex_wen), .ex_is_load_i(ex_ld),
        .mem_rd_i(mem_rd), .mem_wen_i(mem_wen), .mem_is_load_i(mem_ld),
        .mem_is_store_i(mem_st), .mem_rs2_i(mem_rs2),
        .wb_rd_i(wb_rd), .wb_wen_i(wb_wen),
        .pc_we_o(pc_we), .ifid_we_o(ifid_we), .idex_bubble_o(bubble),
        .ifid_squash_o(squash), .pc_redirect_o(redirect),
        .ex_fwd_a_o(exf_a), .ex_fwd_b_o(exf_b),
        .id_fwd_a_o(idf_a), .id_fwd_b_o(idf_b), .st_fwd_o(stf)
    );

    int n_cmp = 0;
    int n_bad = 0;

    function automatic logic same(logic [AW-1:0] a, logic [AW-1:0] b);
        return (a == b) && (a != 0);
    endfunction

    function automatic logic [1:0] m_exfwd(logic [AW-1:0] s);
        if (mem_wen && !mem_ld && same(mem_rd, s)) return 2'd1;
        if (wb_wen && same(wb_rd, s)) return 2'd2;
        return 2'd0;
    endfunction

    function automatic logic m_stall();
        logic r;
        r = 1'b0;
        if (ex_ld && same(ex_rd, id_rs1)) r = 1'b1;
        if (ex_ld && !id_st && same(ex_rd, id_rs2)) r = 1'b1;
        if (id_br && ex_wen && (same(ex_rd, id_rs1) || same(ex_rd, id_rs2))) r = 1'b1;
        if (id_br && mem_ld && (same(mem_rd, id_rs1) || same(mem_rd, id_rs2))) r = 1'b1;
        if (unified && (mem_ld || mem_st)) r = 1'b1;
        return r;
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Compare all outputs against the model; tags say which rule each covers.
    task automatic check_all(string req);
        logic st, sq;
        st = m_stall();
        sq = id_br && id_tk && !st;
        chk(req, "pc_we R1", pc_we, !st);
        chk(req, "ifid_we R1", ifid_we, !st);
        chk(req, "bubble R1", bubble, st);
        chk(req, "squash R9", squash, sq);
        chk(req, "redirect R10", redirect, sq);
        chk(req, "ex_fwd_a R4", exf_a, m_exfwd(ex_rs1));
        chk(req, "ex_fwd_b R4", exf_b, m_exfwd(ex_rs2));
        chk(req, "id_fwd_a R8", idf_a, id_br && mem_wen && !mem_ld && same(mem_rd, id_rs1));
        chk(req, "id_fwd_b R8", idf_b, id_br && mem_wen && !mem_ld && same(mem_rd, id_rs2));
        chk(req, "st_fwd R12", stf, mem_st && wb_wen && same(wb_rd, mem_rs2));
    endtask

    task automatic clear();
        unified = 0; id_st = 0; id_br = 0; id_tk = 0; ex_wen = 0; ex_ld = 0;
        mem_wen = 0; mem_ld = 0; mem_st = 0; wb_wen = 0;
        id_rs1 = 0; id_rs2 = 0; ex_rs1 = 0; ex_rs2 = 0; ex_rd = 0;
        mem_rd = 0; mem_rs2 = 0; wb_rd = 0;
    endtask

    // Apply after a falling edge, settle, then compare.
    task automatic step(string req);
        #2;
        check_all(req);
        @(negedge clk);
    endtask

    initial begin
        clear();
        @(negedge clk);
        // Reset state: idle latches, fetch free.
        chk("R1", "reset pc_we", pc_we, 1);
        chk("R1", "reset bubble", bubble, 0);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: load-use on rs1.
        clear(); ex_ld = 1; ex_wen = 1; ex_rd = 3; id_rs1 = 3;
        step("R2");
        chk("R2", "load-use stall", bubble, 1);
        // R2: store data after load does not stall.
        clear(); ex_ld = 1; ex_wen = 1; ex_rd = 3; id_rs2 = 3; id_st = 1; id_rs1 = 4;
        step("R2");
        chk("R2", "store data no stall", pc_we, 1);
        // R3: ALU result used as load base: no stall, EX/MEM forward next.
        clear(); ex_wen = 1; ex_rd = 1; id_rs1 = 1;
        step("R3");
        chk("R3", "alu->base no stall", pc_we, 1);
        clear(); mem_wen = 1; mem_rd = 1; ex_rs1 = 1; wb_wen = 1; wb_rd = 1;
        step("R4");
        chk("R4", "priority exmem", exf_a, 1);
        clear(); mem_wen = 1; mem_ld = 1; mem_rd = 2; wb_wen = 1; wb_rd = 2; ex_rs2 = 2;
        step("R4");
        chk("R4", "load in mem -> memwb", exf_b, 2);
        // R5: register 0.
        clear(); ex_ld = 1; ex_wen = 1; ex_rd = 0; mem_wen = 1; mem_rd = 0; wb_wen = 1;
        id_br = 1; mem_st = 1;
        step("R5");
        chk("R5", "r0 no stall", pc_we, 1);
        chk("R5", "r0 no fwd", exf_a, 0);
        // R6: WB writer vs decode reader.
        clear(); wb_wen = 1; wb_rd = 5; id_rs1 = 5; id_br = 1;
        step("R6");
        chk("R6", "wb no stall", pc_we, 1);
        chk("R6", "wb no dec fwd", idf_a, 0);
        // R7: ALU -> branch: one stall, then decode forward (R8).
        clear(); id_br = 1; id_tk = 1; id_rs1 = 2; ex_wen = 1; ex_rd = 2;
        step("R7");
        chk("R10", "stall beats squash", squash, 0);
        chk("R10", "no redirect in stall", redirect, 0);
        clear(); id_br = 1; id_tk = 1; id_rs1 = 2; mem_wen = 1; mem_rd = 2;
        step("R8");
        chk("R8", "dec fwd a", idf_a, 1);
        chk("R9", "squash after stall", squash, 1);
        // R7: load -> branch: second stall with load in MEM.
        clear(); id_br = 1; id_rs2 = 6; mem_wen = 1; mem_ld = 1; mem_rd = 6;
        step("R7");
        chk("R7", "load second stall", bubble, 1);
        // R9: not taken.
        clear(); id_br = 1; id_tk = 0;
        step("R9");
        chk("R9", "not taken", redirect, 0);
        // R11: unified vs split.
        clear(); unified = 1; mem_st = 1; id_br = 1; id_tk = 1;
        step("R11");
        chk("R11", "unified stall", ifid_we, 0);
        chk("R10", "unified beats squash", squash, 0);
        clear(); unified = 0; mem_ld = 1; mem_wen = 1; mem_rd = 7;
        step("R11");
        chk("R11", "split no stall", ifid_we, 1);
        // R12: store data forward.
        clear(); mem_st = 1; mem_rs2 = 4; wb_wen = 1; wb_rd = 4;
        step("R12");
        chk("R12", "st fwd", stf, 1);

        // Random phase over registers 0..3.
        void'($urandom(32'd1234));
        for (int i = 0; i < 3000; i++) begin
            unified = $urandom() % 2;
            id_rs1 = $urandom() % 4; id_rs2 = $urandom() % 4;
            id_st = ($urandom() % 4) == 0; id_br = ($urandom() % 3) == 0; id_tk = $urandom() % 2;
            ex_rs1 = $urandom() % 4; ex_rs2 = $urandom() % 4; ex_rd = $urandom() % 4;
            ex_ld = ($urandom() % 3) == 0; ex_wen = ex_ld || ($urandom() % 2);
            mem_rd = $urandom() % 4; mem_rs2 = $urandom() % 4;
            mem_ld = ($urandom() % 3) == 0; mem_st = !mem_ld && (($urandom() % 3) == 0);
            mem_wen = mem_ld || (!mem_st && ($urandom() % 2));
            wb_rd = $urandom() % 4; wb_wen = $urandom() % 2;
            step("RND");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #1000000;
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual 0 expected 1");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule